// File: doc/BRIEF.md
# System Clock Source and Prescaler Controller

This block decides which oscillator paces a small microcontroller and how fast. It is modelled with single-cycle enable pulses ("ticks") rather than gated clocks. Each oscillator presents a tick input. The block picks a fast source (internal RC or crystal) and a slow source (internal RC or crystal). It then emits one system tick stream, either the fast tick divided by a power of two from 1 to 64 or the slow tick unchanged.

Software sets the block through two byte-wide registers on a simple bus, with a one-bit address, a write strobe and a combinational read. The clock-select register holds the division code, the two source choices and two keep-running-in-halt bits. The oscillator register holds the internal fast RC enable, its frequency code and a read-only ready flag.

A new divide code waits for the 6-bit prescaler to wrap before it applies, so no system tick interval is cut short. A new internal RC frequency is reported only after a settling count of 16 internal RC ticks. The oscillator enable outputs follow the halt input and the keep-running bits, but never stop the oscillator that is pacing the system tick.

Top module: `sysclk_ctrl`

## Requirements
- R1: Clock-select register (address 0) reads as {code[2:0] at bits 7:5, 0 at bit 4, fast-crystal select at bit 3, slow-crystal select at bit 2, keep-fast at bit 1, keep-slow at bit 0}. It resets to 0x00, and bit 4 always reads 0 whatever is written.
- R2: Oscillator register (address 1) reads as {0000, freq[1:0] at bits 3:2, ready at bit 1, enable at bit 0} and resets to 0x01. Writes to bit 1 and to bits 7:4 have no effect.
- R3: For codes 0 to 6 the system tick pulses once every 2^code fast ticks. The pulse appears one clock after the fast tick that completes the count.
- R4: Code 7 passes the selected slow tick through to the system tick, delayed by one clock.
- R5: Clock-select bit 3 chooses the fast tick: 0 takes the internal RC tick, 1 takes the crystal tick.
- R6: Clock-select bit 2 chooses the slow tick: 0 takes the internal slow RC tick, 1 takes the slow crystal tick.
- R7: A new divide code applies only when the 6-bit prescaler wraps. Every interval between system ticks therefore equals either the old or the new period.
- R8: Setting the enable bit from 0, or writing a different frequency code while enabled, clears ready. Ready returns to 1 on the 16th internal RC tick after that, and the frequency output keeps its old value until then.
- R9: The frequency output in MHz maps code 00 to 4, 01 to 8, 10 to 12 and 11 to 4.
- R10: When halt is high, the selected fast or slow oscillator enable drops unless its keep bit is 1 or it is pacing the system tick. When halt is low, the selected sources are enabled. The unselected crystal is always off, and the unselected slow RC is off.
- R11: Clearing the enable bit drops the internal RC enable output at once and clears ready one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register address: 0 clock-select, 1 oscillator |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| halt | input | 1 | CPU halted |
| hirc_tick | input | 1 | Internal fast RC tick |
| hxt_tick | input | 1 | Fast crystal tick |
| lirc_tick | input | 1 | Internal slow RC tick |
| lxt_tick | input | 1 | Slow crystal tick |
| sys_tick | output | 1 | System tick pulse |
| hirc_en | output | 1 | Internal fast RC enable |
| hxt_en | output | 1 | Fast crystal enable |
| lirc_en | output | 1 | Internal slow RC enable |
| lxt_en | output | 1 | Slow crystal enable |
| hirc_mhz | output | 4 | Applied internal RC frequency in MHz |

## Verification
The bench switches the divide code mid-stream, fast to slow and back. It checks that no tick interval falls outside the old and new periods; a design that applied the code at once would show a short interval. The ready flag is checked on the 15th and 16th settling ticks. An off-by-one counter, or a frequency output that moved early, would be reported on one of those two cycles. In halt, the pacing oscillator is selected with its keep bit clear, so a design that ignored the in-use exception would drop its enable. Writes to the reserved bit 4 and to the ready bit must read back unchanged, which catches stray storage.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int DIV_W        = 6;
    localparam int SETTLE_TICKS = 16;
    localparam int CODE_W       = 3;
    localparam logic [CODE_W-1:0] SYS_LOW = 3'd7;

    typedef enum logic {
        REG_CSEL = 1'b0,
        REG_OSC  = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic [CODE_W-1:0] sys_code;
        logic              hs_xtal;
        logic              ls_xtal;
        logic              hs_keep;
        logic              ls_keep;
    } csel_t;

    typedef struct packed {
        logic [1:0] freq;
        logic       en;
    } osc_t;

    function automatic logic [7:0] pack_csel(csel_t c);
        return {c.sys_code, 1'b0, c.hs_xtal, c.ls_xtal, c.hs_keep, c.ls_keep};
    endfunction

    function automatic logic [7:0] pack_osc(osc_t o, logic rdy);
        return {4'b0000, o.freq, rdy, o.en};
    endfunction

    function automatic logic [3:0] freq_mhz(logic [1:0] code);
        case (code)
            2'b01:   return 4'd8;
            2'b10:   return 4'd12;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       rdy,
    output csel_t      csel,
    output osc_t       osc,
    output logic       restart,
    output logic [7:0] bus_rdata
);

    logic wr_osc;
    assign wr_osc  = bus_wr && (bus_addr == REG_OSC);
    // settling restarts on an enable edge or a new code while running
    assign restart = wr_osc && bus_wdata[0] && (!osc.en || (bus_wdata[3:2] != osc.freq));

    always_ff @(posedge clk) begin
        if (rst) begin
            csel <= '0;
            osc  <= '{freq: 2'b00, en: 1'b1};
        end else if (bus_wr) begin
            if (bus_addr == REG_CSEL)
                csel <= '{sys_code: bus_wdata[7:5], hs_xtal: bus_wdata[3],
                          ls_xtal: bus_wdata[2], hs_keep: bus_wdata[1],
                          ls_keep: bus_wdata[0]};
            else
                osc <= '{freq: bus_wdata[3:2], en: bus_wdata[0]};
        end
    end

    assign bus_rdata = (bus_addr == REG_CSEL) ? pack_csel(csel) : pack_osc(osc, rdy);

    assert_csel_write_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_CSEL) |=> (csel.sys_code == $past(bus_wdata[7:5])));

endmodule

// File: rtl/sysclk_hirc_ready.sv
module sysclk_hirc_ready
    import sysclk_pkg::*;
#(
    parameter int SETTLE = SETTLE_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] freq,
    output logic       rdy,
    output logic [1:0] freq_act
);

    localparam int CW = $clog2(SETTLE);
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            rdy      <= 1'b0;
            freq_act <= 2'b00;
        end else if (restart || !en) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (!rdy && tick) begin
            if (cnt == LAST) begin
                rdy      <= 1'b1;
                freq_act <= freq;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_freq_held_R8: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> (rdy || $stable(freq_act)));

    assert_ready_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(tick));

    assert_ready_off_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> !rdy);

endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import sysclk_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_tick,
    input  logic              ls_tick,
    input  logic [CODE_W-1:0] sel_code,
    output logic [CODE_W-1:0] act_code,
    output logic              sys_tick
);

    localparam int NTAP = 1 << CODE_W;

    logic [W-1:0]    cnt;
    logic [NTAP-1:0] tap;
    logic            wrap;

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        if (k == 0) begin : g_one
            assign tap[k] = 1'b1;
        end else if (k <= W) begin : g_and
            assign tap[k] = &cnt[k-1:0];
        end else begin : g_none
            assign tap[k] = 1'b0;
        end
    end

    assign wrap = hs_tick && (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            act_code <= '0;
            sys_tick <= 1'b0;
        end else begin
            if (hs_tick) cnt <= cnt + 1'b1;
            if (wrap) act_code <= sel_code;
            sys_tick <= (act_code == SYS_LOW) ? ls_tick : (hs_tick && tap[act_code]);
        end
    end

    assert_code_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (act_code != $past(act_code)) |-> $past(wrap));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (sys_tick && act_code != '0 && act_code != SYS_LOW) |=> !sys_tick);

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sysclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       halt,
    input  logic       hirc_tick,
    input  logic       hxt_tick,
    input  logic       lirc_tick,
    input  logic       lxt_tick,
    output logic       sys_tick,
    output logic       hirc_en,
    output logic       hxt_en,
    output logic       lirc_en,
    output logic       lxt_en,
    output logic [3:0] hirc_mhz
);

    csel_t             csel;
    osc_t              osc;
    logic              restart;
    logic              rdy;
    logic [1:0]        freq_act;
    logic [CODE_W-1:0] act_code;
    logic              hs_tick, ls_tick;
    logic              hs_run, ls_run, from_low;

    sysclk_regs u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .rdy(rdy), .csel(csel), .osc(osc),
        .restart(restart), .bus_rdata(bus_rdata)
    );

    sysclk_hirc_ready #(.SETTLE(SETTLE_TICKS)) u_ready (
        .clk(clk), .rst(rst), .tick(hirc_tick), .en(osc.en),
        .restart(restart), .freq(osc.freq), .rdy(rdy), .freq_act(freq_act)
    );

    assign hs_tick = csel.hs_xtal ? hxt_tick : hirc_tick;
    assign ls_tick = csel.ls_xtal ? lxt_tick : lirc_tick;

    sysclk_divider #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .hs_tick(hs_tick), .ls_tick(ls_tick),
        .sel_code(csel.sys_code), .act_code(act_code), .sys_tick(sys_tick)
    );

    assign from_low = (act_code == SYS_LOW);
    assign hs_run   = !halt || csel.hs_keep || !from_low;
    assign ls_run   = !halt || csel.ls_keep || from_low;

    assign hirc_en  = osc.en && (csel.hs_xtal || hs_run);
    assign hxt_en   = csel.hs_xtal && hs_run;
    assign lirc_en  = !csel.ls_xtal && ls_run;
    assign lxt_en   = csel.ls_xtal && ls_run;
    assign hirc_mhz = freq_mhz(freq_act);

    assert_pacing_src_on_R10: assert property (@(posedge clk) disable iff (rst)
        (halt && !from_low && osc.en && !csel.hs_xtal) |-> hirc_en);

    assert_slow_src_on_R10: assert property (@(posedge clk) disable iff (rst)
        !halt |-> (lirc_en || lxt_en));

endmodule

// File: tb/sysclk_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       halt = 1'b0;
    logic       hirc_tick = 1'b1;
    logic       hxt_tick = 1'b0;
    logic       lirc_tick = 1'b0;
    logic       lxt_tick = 1'b0;
    logic       sys_tick, hirc_en, hxt_en, lirc_en, lxt_en;
    logic [3:0] hirc_mhz;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sysclk_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt(halt),
        .hirc_tick(hirc_tick), .hxt_tick(hxt_tick), .lirc_tick(lirc_tick),
        .lxt_tick(lxt_tick), .sys_tick(sys_tick), .hirc_en(hirc_en),
        .hxt_en(hxt_en), .lirc_en(lirc_en), .lxt_en(lxt_en), .hirc_mhz(hirc_mhz)
    );

    // fast crystal every 2 cycles, slow RC every 5, slow crystal every 3
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            hxt_tick  = (ph % 2 == 0);
            lirc_tick = (ph % 5 == 0);
            lxt_tick  = (ph % 3 == 0);
        end
    end

    // {clock-select byte, expected interval in cycles}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {8'h00, 8'd1}, {8'h20, 8'd2}, {8'h40, 8'd4}, {8'h60, 8'd8},
        {8'h80, 8'd16}, {8'hA0, 8'd32}, {8'hC0, 8'd64}, {8'hE0, 8'd5},
        {8'hE4, 8'd3}, {8'h08, 8'd2}, {8'h48, 8'd8}, {8'hC8, 8'd128}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic meas(output int iv);
        int n;
        while (sys_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (sys_tick !== 1'b1) begin
            @(negedge clk);
            n++;
        end
        iv = n;
    endtask

    function automatic string vec_tag(logic [7:0] b);
        if (b[7:5] == 3'd7) return b[2] ? "R6" : "R4";
        if (b[3]) return "R5";
        return "R3";
    endfunction

    task automatic switch_check(input logic [7:0] b, input int old_iv, input int new_iv);
        int iv;
        wr(1'b0, b);
        for (int i = 0; i < 80; i++) begin
            meas(iv);
            if (iv != old_iv && iv != new_iv)
                chk(1'b0, "R7", "interval during switch", iv, new_iv);
        end
        checks++;
        chk(iv == new_iv, "R7", "interval after switch", iv, new_iv);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int iv1, iv2;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(1'b0, d); chk(d == 8'h00, "R1", "csel reset", d, 8'h00);
        rd(1'b1, d); chk(d == 8'h01, "R2", "osc reset", d, 8'h01);
        chk(hirc_mhz == 4'd4, "R9", "mhz reset", hirc_mhz, 4);
        repeat (20) @(negedge clk);
        rd(1'b1, d); chk(d == 8'h03, "R8", "ready after reset settle", d, 8'h03);

        // reserved bit 4
        wr(1'b0, 8'hFF); rd(1'b0, d); chk(d == 8'hEF, "R1", "csel all ones", d, 8'hEF);
        wr(1'b0, 8'h10); rd(1'b0, d); chk(d == 8'h00, "R1", "bit4 only", d, 8'h00);

        // read-only ready and reserved upper bits
        wr(1'b1, 8'hF3); rd(1'b1, d); chk(d == 8'h03, "R2", "osc F3 write", d, 8'h03);
        wr(1'b1, 8'h01); rd(1'b1, d); chk(d == 8'h03, "R2", "ready not writable", d, 8'h03);

        // settling on frequency changes
        wr(1'b1, 8'h05);
        rd(1'b1, d); chk(d == 8'h05, "R8", "ready cleared on code change", d, 8'h05);
        repeat (15) @(negedge clk);
        rd(1'b1, d); chk(d == 8'h05, "R8", "ready at tick 15", d, 8'h05);
        chk(hirc_mhz == 4'd4, "R8", "mhz held before ready", hirc_mhz, 4);
        @(negedge clk);
        rd(1'b1, d); chk(d == 8'h07, "R8", "ready at tick 16", d, 8'h07);
        chk(hirc_mhz == 4'd8, "R9", "mhz code 01", hirc_mhz, 8);
        wr(1'b1, 8'h09); repeat (17) @(negedge clk);
        chk(hirc_mhz == 4'd12, "R9", "mhz code 10", hirc_mhz, 12);

        // disable then re-enable with code 11
        wr(1'b1, 8'h08);
        chk(hirc_en == 1'b0, "R11", "hirc_en off", hirc_en, 0);
        @(negedge clk);
        rd(1'b1, d); chk(d == 8'h08, "R11", "ready cleared when disabled", d, 8'h08);
        wr(1'b1, 8'h0D);
        rd(1'b1, d); chk(d == 8'h0D, "R8", "ready low after enable", d, 8'h0D);
        repeat (16) @(negedge clk);
        rd(1'b1, d); chk(d == 8'h0F, "R8", "ready after enable", d, 8'h0F);
        chk(hirc_mhz == 4'd4, "R9", "mhz code 11", hirc_mhz, 4);

        // divide and source table
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, VEC[i][15:8]);
            repeat (300) @(negedge clk);
            meas(iv1);
            meas(iv2);
            chk(iv1 == int'(VEC[i][7:0]) && iv2 == int'(VEC[i][7:0]), vec_tag(VEC[i][15:8]),
                "tick interval", iv2, int'(VEC[i][7:0]));
        end

        // switching only at prescaler wrap
        wr(1'b0, 8'h00); repeat (200) @(negedge clk);
        switch_check(8'hA0, 1, 32);
        switch_check(8'h20, 32, 2);

        // halt behaviour
        wr(1'b0, 8'h00); repeat (200) @(negedge clk);
        halt = 1'b1; #1;
        chk(hirc_en == 1'b1, "R10", "pacing fast RC kept in halt", hirc_en, 1);
        chk(lirc_en == 1'b0, "R10", "slow RC stopped in halt", lirc_en, 0);
        chk(hxt_en == 1'b0 && lxt_en == 1'b0, "R10", "crystals off", hxt_en, 0);
        wr(1'b0, 8'h01); #1;
        chk(lirc_en == 1'b1, "R10", "slow RC keep bit", lirc_en, 1);
        wr(1'b0, 8'hE0); repeat (200) @(negedge clk); #1;
        chk(lirc_en == 1'b1, "R10", "pacing slow RC kept", lirc_en, 1);
        chk(hirc_en == 1'b0, "R10", "idle fast RC stopped", hirc_en, 0);
        wr(1'b0, 8'hE2); #1;
        chk(hirc_en == 1'b1, "R10", "fast keep bit", hirc_en, 1);
        wr(1'b0, 8'hEC); #1;
        chk(lxt_en == 1'b1 && lirc_en == 1'b0, "R10", "pacing slow crystal", lxt_en, 1);
        chk(hxt_en == 1'b0, "R10", "idle fast crystal stopped", hxt_en, 0);
        @(negedge clk); halt = 1'b0;
        wr(1'b0, 8'h08); #1;
        chk(hxt_en == 1'b1 && lirc_en == 1'b1 && lxt_en == 1'b0, "R10", "run mode enables",
            {hxt_en, lirc_en, lxt_en}, 3'b110);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule